// File: doc/BRIEF.md
# Timestamped Frame Release Scheduler

This block plays back a list of test frames at exact moments in time. A host pushes vectors into a small internal queue ahead of when they are needed. Each vector is a 32-bit frame (upper half header, lower half payload) plus the absolute tick at which it must go out. The host has already sorted the vectors by that tick. A prescaler divides the system clock down to one tick per 10 µs. A tick counter, cleared by a start strobe, runs freely from then on. When the counter reaches the tick of the vector at the head of the queue, the frame is handed to the serializer that follows. The release time therefore does not depend on how late or how unevenly the host fills the queue.

One frame takes ten ticks on the line, so frames can be scheduled back to back. Some head vectors cannot go out at their scheduled tick: either the tick has already passed, or it falls less than one frame period after the previous release. Such a vector is sent at once, and a sticky late flag records the event. A separate sticky flag records that the queue ran dry during a run. The counter keeps running through such gaps. The tick counter is 32 bits wide, which covers a run of many hours.

Top module: `vector_player`

## Requirements
- R1: After reset, out_valid, running, late_err and underrun are 0, tick_now is 0 and in_ready is 1.
- R2: A start pulse clears tick_now to 0 and sets running. While running, tick_now increases by one every CLK_HZ/TICK_HZ clock cycles. If the start edge is cycle 0, tick_now equals k from cycle 4k to 4k+3 when the ratio is 4.
- R3: A vector is accepted on a cycle with in_valid and in_ready both high. in_ready is 0 while DEPTH vectors are held, and a vector offered then is dropped. Vectors pushed before start are held until the run begins.
- R4: Vectors are released in the order they were pushed. A vector whose stamp is reached on time produces a one-cycle out_valid pulse with its frame on out_frame, one clock after the first cycle in which tick_now equals the stamp. With a ratio of 4, that is cycle 4*stamp+1 after the start edge.
- R5: A head vector whose stamp is smaller than tick_now is released at once, and late_err becomes 1 in the same cycle as its out_valid.
- R6: A head vector whose stamp is smaller than the previous release tick plus FRAME_TICKS is released at once and sets late_err. A stamp exactly FRAME_TICKS after the previous release is released on time and leaves late_err at 0.
- R7: underrun becomes 1 and stays 1 once the queue is empty while running. It stays 0 while the queue still holds vectors, and tick_now keeps advancing after it is set.
- R8: A start pulse clears late_err and underrun and restarts the tick count from 0, even in the middle of a run.
- R9: While running is 0, no frame is released, even when the queue holds vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Strobe: clear tick count and flags, begin the run |
| in_valid | input | 1 | Host offers a vector |
| in_stamp | input | STAMP_W | Release tick of the offered vector |
| in_frame | input | FRAME_W | Frame of the offered vector (header in upper half) |
| in_ready | output | 1 | Queue has room for a vector |
| out_valid | output | 1 | One-cycle pulse: out_frame is to be sent now |
| out_frame | output | FRAME_W | Released frame |
| tick_now | output | STAMP_W | Current tick count |
| running | output | 1 | A run is active |
| late_err | output | 1 | Sticky: a vector was released after its slot |
| underrun | output | 1 | Sticky: queue went empty during the run |

## Verification
Late releases are hard to reach from the ports, because a correctly sorted list never produces one. The stimulus creates both kinds on purpose. In one case a vector is pushed after the counter has already passed its stamp. In the other, two vectors are queued closer together than one frame period, so the second one is released in the cycle right after the first. A pair spaced exactly one frame period apart checks the boundary on the other side. The full-queue condition is produced by filling the queue before start and offering one extra vector, which must never appear at the output.

// File: rtl/vector_player.sv
module vector_player #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int TICK_HZ     = 100_000,
  parameter int FRAME_TICKS = 10,
  parameter int STAMP_W     = 32,
  parameter int FRAME_W     = 32,
  parameter int DEPTH       = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               in_valid,
  input  logic [STAMP_W-1:0] in_stamp,
  input  logic [FRAME_W-1:0] in_frame,
  output logic               in_ready,
  output logic               out_valid,
  output logic [FRAME_W-1:0] out_frame,
  output logic [STAMP_W-1:0] tick_now,
  output logic               running,
  output logic               late_err,
  output logic               underrun
);
  localparam int DIV     = CLK_HZ / TICK_HZ;
  localparam int DIV_W   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int ENTRY_W = STAMP_W + FRAME_W;

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [AW-1:0]      wr_ptr, rd_ptr;
  logic [AW:0]        cnt_q;
  logic [DIV_W-1:0]   div_q;
  logic [STAMP_W-1:0] tick_q, prev_tick;
  logic               have_prev;

  logic               empty, push, fire, div_last, due, past, close;
  logic [STAMP_W-1:0] head_stamp;
  logic [FRAME_W-1:0] head_frame;

  assign empty      = (cnt_q == '0);
  assign in_ready   = (cnt_q != (AW+1)'(DEPTH));
  assign push       = in_valid && in_ready;
  assign head_stamp = mem[rd_ptr][ENTRY_W-1:FRAME_W];
  assign head_frame = mem[rd_ptr][FRAME_W-1:0];
  assign div_last   = (div_q == DIV_W'(DIV - 1));

  assign due   = head_stamp <= tick_q;
  assign past  = head_stamp < tick_q;
  assign close = have_prev &&
                 ({1'b0, head_stamp} < ({1'b0, prev_tick} + (STAMP_W+1)'(FRAME_TICKS)));
  assign fire  = running && !empty && (due || close);

  assign tick_now = tick_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {in_stamp, in_frame};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (fire) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (push && !fire)      cnt_q <= cnt_q + 1'b1;
      else if (fire && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      div_q   <= '0;
      tick_q  <= '0;
    end else if (start) begin
      running <= 1'b1;
      div_q   <= '0;
      tick_q  <= '0;
    end else if (running) begin
      div_q <= div_last ? '0 : div_q + 1'b1;
      if (div_last) tick_q <= tick_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_tick <= '0;
      late_err  <= 1'b0;
      underrun  <= 1'b0;
    end else if (start) begin
      have_prev <= 1'b0;
      late_err  <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      if (fire) begin
        have_prev <= 1'b1;
        prev_tick <= tick_q;
      end
      if (fire && (past || close)) late_err <= 1'b1;
      if (running && empty)        underrun <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_frame <= '0;
    end else begin
      out_valid <= fire;
      if (fire) out_frame <= head_frame;
    end
  end
endmodule

// File: rtl/vector_player_chk.sv
module vector_player_chk #(
  parameter int STAMP_W = 32,
  parameter int DEPTH   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               running,
  input logic               out_valid,
  input logic               late_err,
  input logic               underrun,
  input logic [STAMP_W-1:0] tick_now,
  input logic [$clog2(DEPTH):0] cnt
);
  p_tick_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (tick_now == '0) && running);

  p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running && !start |=> (tick_now == $past(tick_now)) || (tick_now == $past(tick_now) + 1'b1));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(DEPTH)+1)'(DEPTH));

  p_late_on_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_err) |-> out_valid);

  p_late_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    late_err && !start |=> late_err);

  p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun && !start |=> underrun);

  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !late_err && !underrun);

  p_idle_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !out_valid);
endmodule

bind vector_player vector_player_chk #(.STAMP_W(STAMP_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .running(running),
  .out_valid(out_valid), .late_err(late_err), .underrun(underrun),
  .tick_now(tick_now), .cnt(cnt_q)
);

// File: tb/vector_player_bench.sv
module vector_player_bench;
  localparam int NV = 8;
  localparam logic [31:0] T_STAMP [NV] = '{32'd2, 32'd12, 32'd22, 32'd40, 32'd55, 32'd70, 32'd90, 32'd100};
  localparam logic [31:0] T_FRAME [NV] = '{32'hA501_0001, 32'hA502_00FF, 32'h3C00_1234, 32'hFFFF_0000,
                                          32'h0000_FFFF, 32'h5A5A_A5A5, 32'h1111_2222, 32'hDEAD_BEEF};

  logic        clk = 0, rst_n = 0, start = 0, in_valid = 0;
  logic [31:0] in_stamp = '0, in_frame = '0;
  logic        in_ready, out_valid, running, late_err, underrun;
  logic [31:0] out_frame, tick_now;

  int checks = 0, failures = 0, since = 0, rel_cnt = 0, base = 0, cycles = 0;
  int rel_cyc [64];
  logic [31:0] rel_frm [64];

  always #2 clk = ~clk;

  vector_player #(.CLK_HZ(1000), .TICK_HZ(250), .FRAME_TICKS(10), .DEPTH(16)) u_vector_player (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_stamp(in_stamp),
    .in_frame(in_frame), .in_ready(in_ready), .out_valid(out_valid), .out_frame(out_frame),
    .tick_now(tick_now), .running(running), .late_err(late_err), .underrun(underrun));

  always @(posedge clk) begin
    since  <= start ? 0 : since + 1;
    cycles <= cycles + 1;
  end

  always @(negedge clk) begin
    if (out_valid && rel_cnt < 64) begin
      rel_cyc[rel_cnt] = since;
      rel_frm[rel_cnt] = out_frame;
      rel_cnt = rel_cnt + 1;
    end
    if (cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not complete (act=%0d exp<=100000 cycles)", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] s, input logic [31:0] f);
    in_valid = 1; in_stamp = s; in_frame = f;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_since(input int n);
    while (since != n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    base = rel_cnt;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid && !running, "R1", "out_valid/running after reset", {out_valid, running}, 0);
    chk(!late_err && !underrun, "R1", "flags after reset", {late_err, underrun}, 0);
    chk(tick_now == 0 && in_ready, "R1", "tick/in_ready after reset", {tick_now, in_ready}, 1);

    // Table run: all vectors on time
    base = rel_cnt;
    for (int i = 0; i < NV; i++) push(T_STAMP[i], T_FRAME[i]);
    in_valid = 0;
    repeat (10) @(negedge clk);
    chk(rel_cnt == base, "R9", "no release before start", rel_cnt - base, 0);
    chk(tick_now == 0, "R9", "tick idle before start", tick_now, 0);
    pulse_start();
    wait_since(39);
    chk(tick_now == 9, "R2", "tick at cycle 39", tick_now, 9);
    wait_since(41);
    chk(tick_now == 10, "R2", "tick at cycle 41", tick_now, 10);
    wait_since(200);
    chk(!underrun, "R7", "no underrun while queue holds vectors", underrun, 0);
    wait_since(450);
    chk(rel_cnt - base == NV, "R4", "release count", rel_cnt - base, NV);
    for (int i = 0; i < NV; i++) begin
      chk(rel_frm[base+i] == T_FRAME[i], "R4", "frame order", rel_frm[base+i], T_FRAME[i]);
      chk(rel_cyc[base+i] == 4*int'(T_STAMP[i]) + 1, "R4", "release cycle", rel_cyc[base+i], 4*T_STAMP[i] + 1);
    end
    chk(!late_err, "R4", "no late flag for sorted list", late_err, 0);
    chk(underrun, "R7", "underrun after queue drained", underrun, 1);
    chk(tick_now == 112, "R7", "tick keeps running", tick_now, 112);

    // R8: restart mid-run clears flags and tick
    pulse_start();
    chk(tick_now == 0 && !underrun && !late_err, "R8", "restart clears", {tick_now, underrun, late_err}, 0);

    // R5: stamp already in the past
    base = rel_cnt;
    wait_since(40);
    push(32'd3, 32'hCAFE_0005);
    in_valid = 0;
    repeat (5) @(negedge clk);
    chk(rel_cnt - base == 1 && rel_frm[base] == 32'hCAFE_0005, "R5", "past vector released", rel_frm[base], 32'hCAFE_0005);
    chk(rel_cyc[base] <= 43, "R5", "past vector sent at once", rel_cyc[base], 43);
    chk(late_err, "R5", "late flag for past stamp", late_err, 1);
    pulse_start();
    chk(!late_err, "R8", "start clears late flag", late_err, 0);

    // R6: spacing below one frame period
    do_reset();
    push(32'd4, 32'h0006_0001);
    push(32'd10, 32'h0006_0002);
    in_valid = 0;
    pulse_start();
    wait_since(17);
    chk(!late_err, "R6", "first vector on time", late_err, 0);
    wait_since(30);
    chk(rel_cyc[base] == 17, "R6", "first release cycle", rel_cyc[base], 17);
    chk(rel_cyc[base+1] == 18 && rel_frm[base+1] == 32'h0006_0002, "R6", "close vector sent at once", rel_cyc[base+1], 18);
    chk(late_err, "R6", "late flag for close spacing", late_err, 1);

    // R6 boundary: exactly one frame period apart
    do_reset();
    push(32'd4, 32'h0007_0001);
    push(32'd14, 32'h0007_0002);
    in_valid = 0;
    pulse_start();
    wait_since(70);
    chk(rel_cyc[base+1] == 57, "R6", "boundary release cycle", rel_cyc[base+1], 57);
    chk(!late_err, "R6", "no late flag at exact spacing", late_err, 0);

    // R3: fill queue, extra vector dropped
    do_reset();
    for (int i = 0; i < 17; i++) begin
      chk(in_ready == (i < 16), "R3", "in_ready while filling", in_ready, i < 16);
      push(32'(10*i), 32'hBB00_0000 | 32'(i));
    end
    in_valid = 0;
    chk(!in_ready, "R3", "in_ready low when full", in_ready, 0);
    chk(rel_cnt == base, "R9", "held vectors not released before start", rel_cnt - base, 0);
    pulse_start();
    wait_since(620);
    chk(rel_cnt - base == 16, "R3", "dropped extra vector", rel_cnt - base, 16);
    for (int i = 0; i < 16; i++)
      chk(rel_frm[base+i] == (32'hBB00_0000 | 32'(i)), "R3", "held vector order", rel_frm[base+i], 32'hBB00_0000 | 32'(i));
    chk(in_ready, "R3", "in_ready back after drain", in_ready, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule